// File: doc/BRIEF.md
# AES-Round Shift-Register State Updater

This block keeps a wide internal state made of `NWORDS` words of 128 bits each. It advances that state by one step in every cycle in which a message is accepted. In a step every word moves one place up, and the top word wraps around to position 0. At positions marked in an elaboration-time mask, the arriving word passes through one AES round. The word that held that position before the step is the round key. At other positions a feed-forward XOR of the word's prior value may be added. Up to three 128-bit message blocks arrive with each step, and each position XORs in the blocks its injection mask selects.

All AES rounds of a step read only the state as it was before the step, so they are independent of one another. They are all computed side by side in one cycle. Two wirings are foreseen. The default has 12 words, 6 rounds and 3 blocks per step, which is 2 rounds per 16 input bytes. A 6-word wiring has a round at every position and takes 2 blocks per step, which is 3 rounds per 16 bytes. A load port writes the whole state in one cycle, and a read port shows the registered state.

Top module: `aesstep_updater`

## Requirements
- R1: A synchronous active-high `rst` clears every state word to zero on the next rising edge, and `msg_ready` is high while `load_en` is low.
- R2: In a step (`msg_valid` and `msg_ready` high at a rising edge), a position j whose `AES_MASK` bit is 0 takes word j-1 of the old state. If `FF_MASK[j]` is set, the old word j is XORed in as well. Word j occupies `state_out[128*j+127 : 128*j]`.
- R3: In a step, a position j whose `AES_MASK` bit is 1 takes MixColumns(ShiftRows(SubBytes(old word j-1))) XOR old word j. Byte n of a word sits at bits [127-8n : 120-8n], and byte n is row n%4 of column n/4.
- R4: In a step, each position XORs in every message block k whose bit `INJ_MASK[k*NWORDS + j]` is set. Block k sits at `msg_data[128*k+127 : 128*k]`.
- R5: When `msg_valid` is low and `load_en` is low, the state is unchanged at the rising edge, whatever `msg_data` holds.
- R6: When `load_en` is high, the whole state takes `load_state` at the rising edge, even if `msg_valid` is high. `msg_ready` is low during such a cycle.
- R7: Position 0 draws its source from word NWORDS-1 (wrap-around of the shift).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_state` into the whole state |
| load_state | input | NWORDS*128 | State value to load |
| msg_valid | input | 1 | Message blocks present |
| msg_ready | output | 1 | Block can take a step this cycle |
| msg_data | input | NBLK*128 | Message blocks, block k in slice k |
| state_out | output | NWORDS*128 | Registered state |

## Verification
The checker assumes that `rst` is asserted at the first clock edge. It also assumes that the message blocks and the load value are steady around each rising edge, so that the value seen one cycle later can be related to a single sampled input. The bench changes inputs only on falling edges, starts with reset held high, and keeps `load_en` a full cycle wide. Every step is checked against an AES round model inside the bench for both wirings. The stimulus mixes loads, idle cycles and steps at random, so that a load can coincide with a valid message.

// File: rtl/aesstep_pkg.sv
`timescale 1ns/1ps
package aesstep_pkg;
  localparam int WORD_W = 128;
  localparam int NBYTES = WORD_W / 8;
  localparam int NCOL   = NBYTES / 4;

  typedef logic [WORD_W-1:0] word_t;

  // multiply by x in GF(2^8) with the AES polynomial
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xtime(t);
    end
    return p;
  endfunction

  // a^254 by repeated squaring: the field inverse, 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  // substitution byte: inverse followed by the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aesstep_sbox.sv
`timescale 1ns/1ps
module aesstep_sbox
  import aesstep_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  // pure function of one byte; synthesis folds it into a 256-entry lookup
  assign dout = sbox_calc(din);
endmodule

// File: rtl/aesstep_round.sv
`timescale 1ns/1ps
module aesstep_round
  import aesstep_pkg::*;
(
  input  word_t din,
  input  word_t key,
  output word_t dout
);
  logic [7:0] sb [NBYTES];
  logic [7:0] sr [NBYTES];
  word_t      mc;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    aesstep_sbox u_sbox (
      .din  (din[WORD_W-1-8*b -: 8]),
      .dout (sb[b])
    );
  end

  // row r of column c comes from column c+r
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      for (int r = 0; r < 4; r++) begin
        sr[4*c+r] = sb[4*((c+r)%NCOL)+r];
      end
    end
  end

  always_comb begin
    logic [7:0] a0, a1, a2, a3;
    mc = '0;
    for (int c = 0; c < NCOL; c++) begin
      a0 = sr[4*c];
      a1 = sr[4*c+1];
      a2 = sr[4*c+2];
      a3 = sr[4*c+3];
      mc[WORD_W-1-8*(4*c)   -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      mc[WORD_W-1-8*(4*c+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      mc[WORD_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      mc[WORD_W-1-8*(4*c+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
  end

  assign dout = mc ^ key;
endmodule

// File: rtl/aesstep_net.sv
`timescale 1ns/1ps
module aesstep_net
  import aesstep_pkg::*;
#(
  parameter int NWORDS = 12,
  parameter int NBLK   = 3,
  parameter logic [NWORDS-1:0]      AES_MASK = 12'hAAA,
  parameter logic [NWORDS-1:0]      FF_MASK  = 12'h041,
  parameter logic [NBLK*NWORDS-1:0] INJ_MASK = 36'h222450105,
  localparam int STATE_W = NWORDS * WORD_W,
  localparam int MSG_W   = NBLK * WORD_W
) (
  input  logic [STATE_W-1:0] cur,
  input  logic [MSG_W-1:0]   msg,
  output logic [STATE_W-1:0] nxt
);
  for (genvar j = 0; j < NWORDS; j++) begin : g_pos
    localparam int SRC = (j == 0) ? NWORDS - 1 : j - 1;
    word_t src_w;
    word_t own_w;
    word_t base_w;
    word_t inj_w;

    assign src_w = cur[SRC*WORD_W +: WORD_W];
    assign own_w = cur[j*WORD_W +: WORD_W];

    always_comb begin
      inj_w = '0;
      for (int k = 0; k < NBLK; k++) begin
        if (INJ_MASK[k*NWORDS+j]) inj_w = inj_w ^ msg[k*WORD_W +: WORD_W];
      end
    end

    if (AES_MASK[j]) begin : g_aes
      // the word leaving this place is the round key
      aesstep_round u_round (
        .din  (src_w),
        .key  (own_w),
        .dout (base_w)
      );
    end else if (FF_MASK[j]) begin : g_ff
      assign base_w = src_w ^ own_w;
    end else begin : g_pass
      assign base_w = src_w;
    end

    assign nxt[j*WORD_W +: WORD_W] = base_w ^ inj_w;
  end
endmodule

// File: rtl/aesstep_updater.sv
`timescale 1ns/1ps
module aesstep_updater
  import aesstep_pkg::*;
#(
  parameter int NWORDS = 12,
  parameter int NBLK   = 3,
  parameter logic [NWORDS-1:0]      AES_MASK = 12'hAAA,
  parameter logic [NWORDS-1:0]      FF_MASK  = 12'h041,
  parameter logic [NBLK*NWORDS-1:0] INJ_MASK = 36'h222450105,
  localparam int STATE_W = NWORDS * WORD_W,
  localparam int MSG_W   = NBLK * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_state,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [MSG_W-1:0]   msg_data,
  output logic [STATE_W-1:0] state_out
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] step_d;

  aesstep_net #(
    .NWORDS   (NWORDS),
    .NBLK     (NBLK),
    .AES_MASK (AES_MASK),
    .FF_MASK  (FF_MASK),
    .INJ_MASK (INJ_MASK)
  ) u_net (
    .cur (state_q),
    .msg (msg_data),
    .nxt (step_d)
  );

  assign msg_ready = ~load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (load_en) begin
      state_q <= load_state;
    end else if (msg_valid && msg_ready) begin
      state_q <= step_d;
    end
  end

  assign state_out = state_q;
endmodule

// File: rtl/aesstep_updater_chk.sv
`timescale 1ns/1ps
module aesstep_updater_chk
  import aesstep_pkg::*;
#(
  parameter int NWORDS = 12,
  parameter int NBLK   = 3,
  parameter logic [NWORDS-1:0]      AES_MASK = 12'hAAA,
  parameter logic [NWORDS-1:0]      FF_MASK  = 12'h041,
  parameter logic [NBLK*NWORDS-1:0] INJ_MASK = 36'h222450105,
  localparam int STATE_W = NWORDS * WORD_W,
  localparam int MSG_W   = NBLK * WORD_W
) (
  input logic               clk,
  input logic               rst,
  input logic               load_en,
  input logic [STATE_W-1:0] load_state,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [MSG_W-1:0]   msg_data,
  input logic [STATE_W-1:0] state_out
);
  function automatic word_t inj_of(input logic [MSG_W-1:0] m, input int j);
    word_t acc;
    acc = '0;
    for (int k = 0; k < NBLK; k++) begin
      if (INJ_MASK[k*NWORDS+j]) acc = acc ^ m[k*WORD_W +: WORD_W];
    end
    return acc;
  endfunction

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> state_out == '0); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!load_en && !msg_valid) |=> $stable(state_out)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) load_en |=> state_out == $past(load_state)); // R6

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    if (!AES_MASK[j]) begin : g_plain
      localparam int SRC = (j == 0) ? NWORDS - 1 : j - 1;
      AST_SHIFT_WORD: assert property (@(posedge clk) disable iff (rst) (msg_valid && msg_ready) |=> state_out[j*WORD_W +: WORD_W] == ($past(state_out[SRC*WORD_W +: WORD_W]) ^ (FF_MASK[j] ? $past(state_out[j*WORD_W +: WORD_W]) : {WORD_W{1'b0}}) ^ inj_of($past(msg_data), j))); // R2 R4 R7
    end
  end
endmodule

bind aesstep_updater aesstep_updater_chk #(
  .NWORDS   (NWORDS),
  .NBLK     (NBLK),
  .AES_MASK (AES_MASK),
  .FF_MASK  (FF_MASK),
  .INJ_MASK (INJ_MASK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_en    (load_en),
  .load_state (load_state),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_data   (msg_data),
  .state_out  (state_out)
);

// File: tb/test_aesstep_updater.sv
`timescale 1ns/1ps
module test_aesstep_updater;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic msg_valid = 1'b0;
  logic [1535:0] ld_big = '0;
  logic [767:0]  ld_small = '0;
  logic [383:0]  msg = '0;
  logic [1535:0] out_big;
  logic [767:0]  out_small;
  logic rdy_big, rdy_small;

  int checks = 0;
  int errors = 0;

  logic [1535:0] mb = '0;
  logic [1535:0] ms = '0;
  logic [1535:0] qb[$];
  logic [1535:0] qs[$];
  string rq[$];

  always #2 clk = ~clk;

  aesstep_updater i_aesstep_updater (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(ld_big),
    .msg_valid(msg_valid), .msg_ready(rdy_big), .msg_data(msg),
    .state_out(out_big)
  );

  aesstep_updater #(
    .NWORDS(6), .NBLK(2), .AES_MASK(6'h3F), .FF_MASK(6'h00), .INJ_MASK(12'h201)
  ) i_aesstep_updater_small (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(ld_small),
    .msg_valid(msg_valid), .msg_ready(rdy_small), .msg_data(msg[255:0]),
    .state_out(out_small)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    logic hi;
    p = 0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      hi = x[7];
      x = x << 1;
      if (hi) x ^= 8'h1b;
    end
    return p;
  endfunction

  function automatic logic [7:0] tsbox(input logic [7:0] x);
    logic [7:0] inv, o;
    logic [7:0] c;
    inv = 0; c = 8'h63;
    for (int y = 1; y < 256; y++) if (tmul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [127:0] trnd(input logic [127:0] x);
    logic [7:0] s[16];
    logic [7:0] t[16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = tsbox(x[127-8*i -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = tmul(8'h02, t[4*c+r]) ^ tmul(8'h03, t[4*c+(r+1)%4]) ^
                                t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
    return o;
  endfunction

  function automatic logic [1535:0] mdl(input logic [1535:0] st, input int n,
      input logic [11:0] am, input logic [11:0] fm, input logic [11:0] m1,
      input logic [11:0] m2, input logic [11:0] m3, input logic [383:0] m);
    logic [1535:0] r;
    logic [127:0] src, own, v;
    r = '0;
    for (int j = 0; j < n; j++) begin
      src = st[((j+n-1)%n)*128 +: 128];
      own = st[j*128 +: 128];
      if (am[j]) v = trnd(src) ^ own;
      else if (fm[j]) v = src ^ own;
      else v = src;
      if (m1[j]) v ^= m[127:0];
      if (m2[j]) v ^= m[255:128];
      if (m3[j]) v ^= m[383:256];
      r[j*128 +: 128] = v;
    end
    return r;
  endfunction

  function automatic logic [1535:0] rstate();
    logic [1535:0] r;
    for (int i = 0; i < 48; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string req, input logic [1535:0] act, input logic [1535:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected state
  task automatic drive(input bit ld, input logic [1535:0] lb, input logic [767:0] ls,
                       input bit v, input logic [383:0] m, input string req);
    @(negedge clk);
    load_en = ld; ld_big = lb; ld_small = ls; msg_valid = v; msg = m;
    if (ld) begin
      mb = lb;
      ms = {768'b0, ls};
    end else if (v) begin
      mb = mdl(mb, 12, 12'hAAA, 12'h041, 12'h105, 12'h450, 12'h222, m);
      ms = mdl(ms, 6, 12'h03F, 12'h000, 12'h001, 12'h008, 12'h000, {128'b0, m[255:0]});
    end
    qb.push_back(mb); qs.push_back(ms); rq.push_back(req);
    #1;
    chk(rdy_big == !ld && rdy_small == !ld, "R6 ready", {1534'b0, rdy_big, rdy_small}, {1534'b0, !ld, !ld});
  endtask

  // monitor: compare each queued expectation after its edge
  initial begin
    logic [1535:0] eb, es;
    string r;
    forever begin
      @(posedge clk);
      #1;
      if (qb.size() > 0) begin
        eb = qb.pop_front(); es = qs.pop_front(); r = rq.pop_front();
        chk(out_big == eb, r, out_big, eb);
        chk(out_small == es[767:0], r, {768'b0, out_small}, es);
      end
    end
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1535:0] kat;
    logic [127:0] z, x;
    logic [383:0] m;
    bit ld, v;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_big == '0 && out_small == '0, "R1 reset state", out_big, '0);
    chk(rdy_big && rdy_small, "R1 ready after reset", {1534'b0, rdy_big, rdy_small}, 1536'h3);

    // known answer: zero state, zero message
    drive(0, '0, '0, 1, '0, "R3 zero step");
    @(posedge clk); #1;
    chk(out_small == {96{8'h63}}, "R3 known answer small", {768'b0, out_small}, {768'b0, {96{8'h63}}});
    kat = '0;
    for (int j = 1; j < 12; j += 2) kat[j*128 +: 128] = {16{8'h63}};
    chk(out_big == kat, "R3 known answer big", out_big, kat);

    // single block injection
    z = {$urandom, $urandom, $urandom, $urandom};
    drive(1, '0, '0, 0, '0, "R6 clear load");
    drive(0, '0, '0, 1, {128'b0, z, 128'b0}, "R4 block two only");
    @(posedge clk); #1;
    chk(out_big[4*128 +: 128] == z && out_big[10*128 +: 128] == z && out_big[127:0] == '0,
        "R4 big injection", {out_big[10*128 +: 128], out_big[4*128 +: 128], out_big[127:0]},
        {z, z, 128'b0});
    chk(out_small[3*128 +: 128] == ({16{8'h63}} ^ z), "R4 small injection",
        {1408'b0, out_small[3*128 +: 128]}, {1408'b0, {16{8'h63}} ^ z});

    // wrap-around
    x = {$urandom, $urandom, $urandom, $urandom};
    drive(1, {x, 1408'b0}, {x, 640'b0}, 0, '0, "R6 load top word");
    drive(0, '0, '0, 1, '0, "R7 wrap step");
    @(posedge clk); #1;
    chk(out_big[127:0] == x, "R7 wrap big", {1408'b0, out_big[127:0]}, {1408'b0, x});

    // load and valid together
    drive(1, rstate(), rstate() >> 768, 1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, "R6 load beats step");

    // plain steps
    for (int i = 0; i < 16; i++) begin
      m = {rstate()[383:0]};
      drive(0, '0, '0, 1, m, "R2/R3/R4 step");
    end

    // idle with changing message
    for (int i = 0; i < 4; i++) drive(0, rstate(), rstate() >> 768, 0, rstate()[383:0], "R5 idle");

    // mixed traffic
    for (int i = 0; i < 30; i++) begin
      ld = ($urandom % 6) == 0;
      v  = ($urandom % 4) != 0;
      drive(ld, rstate(), rstate() >> 768, v, rstate()[383:0],
            ld ? "R6 mixed load" : (v ? "R2/R3/R4 mixed step" : "R5 mixed idle"));
    end

    drive(0, '0, '0, 0, '0, "R5 final idle");
    @(negedge clk);
    rst = 1'b1; msg_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; msg_valid = 1'b0;
    #1;
    chk(out_big == '0 && out_small == '0, "R1 reset mid-run", out_big, '0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule